// File: doc/BRIEF.md
# Flash Block Lock State Manager

This block holds the protection state of every erase block in a flash array. Software writes three lock commands (lock, unlock and lock-down), each aimed at a block index. A write is taken when the active-low write strobe rises while chip enable is low. For any queried block the manager reports its locked bit and its lock-down mark, and whether program or erase may go ahead.

Two pins shape the result beyond software. An active-low power-down/reset input puts the whole array back to locked and wipes every lock-down mark. An active-low write-protect input decides whether a lock-down mark really freezes its block. A digital supply-lockout flag vetoes every program or erase regardless of lock state. The lock-down mark is kept apart from the locked bit, so a block that software unlocked while write-protect was high is frozen again as soon as write-protect returns low.

Top module: `flash_lock_mgr`

## Requirements
- R1: While `pd_n` is low, `out_drv` is 0, every block is forced locked with its mark cleared one clock later, and commands are ignored.
- R2: After `rst_n` reset or after `pd_n` returns high, every block reads locked (`q_locked`=1) with no mark (`q_lkdn`=0).
- R3: A command is taken only in the clock cycle where `we_n` is first sampled high after being low, and only if `ce_n` is low in that cycle; `cmd_blk` and `cmd_code` are taken from that same cycle.
- R4: Code 8'h4C locks the addressed block and code 8'h55 unlocks it; both take effect at the capturing clock edge.
- R5: Code 8'h44 (lock-down) sets both the locked bit and the mark; while `wp_n` is low an unlock of a marked block leaves it locked.
- R6: While `wp_n` is high, a marked block may be unlocked and locked again by software.
- R7: While `wp_n` is low, every marked block is locked again one clock later, including a block software unlocked while `wp_n` was high.
- R8: While `vpp_low` is 1, `pe_ok` is 0 whatever the lock state.
- R9: `pe_ok` is 1 exactly when `pd_n` is high, `vpp_low` is 0 and the queried block is unlocked.
- R10: A command code other than 8'h4C, 8'h55 and 8'h44 changes no block.
- R11: A lock-down command given while `wp_n` is high still records the mark, and no software command clears a mark.
- R12: `out_drv` equals 1 exactly when `pd_n` is high and both `ce_n` and `oe_n` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down / array reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe; command taken on its rise |
| oe_n | input | 1 | Active-low output enable |
| wp_n | input | 1 | Active-low write protect, arms lock-down |
| vpp_low | input | 1 | Program/erase supply below lockout level |
| cmd_blk | input | IDX_W | Block index of a command |
| cmd_code | input | 8 | Command code |
| q_blk | input | IDX_W | Block index being queried |
| q_locked | output | 1 | Locked bit of the queried block |
| q_lkdn | output | 1 | Lock-down mark of the queried block |
| pe_ok | output | 1 | Program/erase permitted on the queried block |
| out_drv | output | 1 | Data outputs driven (0 means high impedance) |

## Verification
A command changes state at the clock edge where the rising write strobe is first sampled, so its result is due after that one edge; the re-lock from write-protect low and the forcing from power-down are likewise due one edge after the pin is sampled. The query outputs, `pe_ok` and `out_drv` are combinational from that state and the pins, so they follow `q_blk`, `vpp_low`, `ce_n` and `oe_n` with no delay. The driver changes inputs only on falling clock edges and queues each expected item after the relevant rising edge; the monitor pops it on a later falling edge, sets the query index and compares a nanosecond afterwards.

// File: rtl/flm_pkg.sv
// Package: shared command codes and decoded operation type for the
// flash block lock manager. Assumes an 8-bit command code field.
package flm_pkg;
    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] CODE_LOCK   = 8'h4C;
    localparam logic [CODE_W-1:0] CODE_UNLOCK = 8'h55;
    localparam logic [CODE_W-1:0] CODE_LKDN   = 8'h44;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_LKDN   = 2'd3
    } lock_op_e;
endpackage

// File: rtl/flm_cmd_capture.sv
// Command capture: detects the rise of the active-low write strobe and
// decodes the code present in that cycle into a one-cycle operation.
// Assumes ce_n, cmd_blk and cmd_code are stable around the strobe rise.
module flm_cmd_capture #(
    parameter int IDX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ce_n,
    input  logic                      we_n,
    input  logic [IDX_W-1:0]          cmd_blk,
    input  logic [flm_pkg::CODE_W-1:0] cmd_code,
    output flm_pkg::lock_op_e         op,
    output logic [IDX_W-1:0]          op_blk
);
    import flm_pkg::*;

    logic we_q;
    logic take;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    // A rise of the strobe with the chip selected is a command.
    assign take = !we_q && we_n && !ce_n;

    // Decode the captured code; unknown codes decode to no operation.
    always_comb begin
        op = OP_NONE;
        if (take) begin
            case (cmd_code)
                CODE_LOCK:   op = OP_LOCK;
                CODE_UNLOCK: op = OP_UNLOCK;
                CODE_LKDN:   op = OP_LKDN;
                default:     op = OP_NONE;
            endcase
        end
    end

    assign op_blk = cmd_blk;

    // R3: a strobe rise yields one operation, never two in a row.
    a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_NONE) |=> (op == OP_NONE));
endmodule

// File: rtl/flm_lock_bank.sv
// Lock bank: one locked bit and one lock-down mark per erase block.
// Assumes op is valid for a single cycle; power-down overrides all else.
module flm_lock_bank #(
    parameter int NBLK  = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              wp_n,
    input  flm_pkg::lock_op_e op,
    input  logic [IDX_W-1:0]  op_blk,
    output logic [NBLK-1:0]   lk,
    output logic [NBLK-1:0]   mk
);
    import flm_pkg::*;

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        logic hit;
        logic lk_n;
        logic mk_n;

        assign hit = (op_blk == IDX_W'(i));

        // Next state of this block from the command and write-protect.
        always_comb begin
            lk_n = lk[i];
            mk_n = mk[i];
            if (hit) begin
                case (op)
                    OP_LOCK:   lk_n = 1'b1;
                    OP_UNLOCK: if (!(mk[i] && !wp_n)) lk_n = 1'b0;
                    OP_LKDN: begin
                        lk_n = 1'b1;
                        mk_n = 1'b1;
                    end
                    default: ;
                endcase
            end
            if (!wp_n && mk_n) lk_n = 1'b1;
        end

        // State register; reset and power-down lock all and clear marks.
        always_ff @(posedge clk) begin
            if (!rst_n || !pd_n) begin
                lk[i] <= 1'b1;
                mk[i] <= 1'b0;
            end else begin
                lk[i] <= lk_n;
                mk[i] <= mk_n;
            end
        end

        // R5: a marked block under write-protect stays locked.
        a_r5_lkdn_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!wp_n && mk[i] && lk[i]) |=> lk[i]);
        // R7: write-protect low re-locks a marked block.
        a_r7_reapply: assert property (@(posedge clk) disable iff (!rst_n)
            (!wp_n && mk[i]) |=> lk[i]);
        // R11: only power-down removes a mark.
        a_r11_mark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (mk[i] && pd_n) |=> mk[i]);
    end

    // R1: power-down leaves every block locked and unmarked.
    a_r1_pd_force: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> ((&lk) && (mk == '0)));
endmodule

// File: rtl/flash_lock_mgr.sv
// Flash block lock manager top: captures lock commands, keeps per-block
// lock state and answers queries on one block at a time.
// Assumes all inputs are synchronous to clk.
module flash_lock_mgr #(
    parameter int NBLK  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             ce_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             wp_n,
    input  logic             vpp_low,
    input  logic [IDX_W-1:0] cmd_blk,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] q_blk,
    output logic             q_locked,
    output logic             q_lkdn,
    output logic             pe_ok,
    output logic             out_drv
);
    import flm_pkg::*;

    lock_op_e         op;
    logic [IDX_W-1:0] op_blk;
    logic [NBLK-1:0]  lk;
    logic [NBLK-1:0]  mk;
    logic             in_rng;

    flm_cmd_capture #(.IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .cmd_blk(cmd_blk), .cmd_code(cmd_code), .op(op), .op_blk(op_blk)
    );

    flm_lock_bank #(.NBLK(NBLK), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wp_n(wp_n),
        .op(pd_n ? op : OP_NONE), .op_blk(op_blk), .lk(lk), .mk(mk)
    );

    // Select the queried block; an index past the array reads locked.
    assign in_rng = (32'(q_blk) < NBLK);
    always_comb begin
        q_locked = 1'b1;
        q_lkdn   = 1'b0;
        if (in_rng) begin
            q_locked = lk[q_blk];
            q_lkdn   = mk[q_blk];
        end
    end

    // Program/erase needs an unlocked block, a good supply, no power-down.
    assign pe_ok   = pd_n && !vpp_low && !q_locked;
    // Data outputs float in power-down or when not selected for reading.
    assign out_drv = pd_n && !ce_n && !oe_n;

    // R8: supply lockout vetoes program/erase.
    a_r8_vpp_veto: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_low |-> !pe_ok);
    // R1: outputs float in power-down.
    a_r1_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> !out_drv);
    // R9: a locked block never permits program/erase.
    a_r9_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        q_locked |-> !pe_ok);
endmodule

// File: tb/test_flash_lock_mgr.sv
module test_flash_lock_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b1;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       wp_n = 1'b0;
    logic       vpp_low = 1'b0;
    logic [2:0] cmd_blk = '0;
    logic [7:0] cmd_code = '0;
    logic [2:0] q_blk = '0;
    logic       q_locked, q_lkdn, pe_ok, out_drv;

    int n_vec = 0;
    int n_bad = 0;
    bit exp_lk [8];
    bit exp_mk [8];

    typedef struct {
        logic [2:0] blk;
        bit         lk;
        bit         mk;
        bit         pe;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    flash_lock_mgr i_flash_lock_mgr (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .wp_n(wp_n), .vpp_low(vpp_low), .cmd_blk(cmd_blk),
        .cmd_code(cmd_code), .q_blk(q_blk), .q_locked(q_locked),
        .q_lkdn(q_lkdn), .pe_ok(pe_ok), .out_drv(out_drv)
    );

    task automatic cmp(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected item and compares the design's answer.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sbq.size() != 0) begin
                it = sbq.pop_front();
                q_blk = it.blk;
                #1;
                cmp({it.tag, " locked"}, int'(q_locked), int'(it.lk));
                cmp({it.tag, " mark"},   int'(q_lkdn),   int'(it.mk));
                cmp({it.tag, " pe_ok"},  int'(pe_ok),    int'(it.pe));
            end
        end
    end

    // Push the model's view of one block and let the monitor consume it.
    task automatic chk(int b, string tag);
        item_t it;
        it.blk = 3'(b);
        it.lk  = exp_lk[b];
        it.mk  = exp_mk[b];
        it.pe  = !exp_lk[b] && !vpp_low && pd_n;
        it.tag = tag;
        sbq.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    // Driver: one write strobe, updating the model per the requirements.
    task automatic wr(int b, logic [7:0] code, bit sel);
        @(negedge clk);
        ce_n = !sel; we_n = 1'b0; cmd_blk = 3'(b); cmd_code = code;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        if (sel && pd_n) begin
            case (code)
                8'h4C: exp_lk[b] = 1'b1;
                8'h55: if (!(exp_mk[b] && !wp_n)) exp_lk[b] = 1'b0;
                8'h44: begin exp_lk[b] = 1'b1; exp_mk[b] = 1'b1; end
                default: ;
            endcase
        end
    endtask

    task automatic all_locked_model();
        for (int k = 0; k < 8; k++) begin
            exp_lk[k] = 1'b1;
            exp_mk[k] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        all_locked_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset leaves every block locked and unmarked; R9 pe_ok low.
        for (int k = 0; k < 8; k++) chk(k, "R2 reset");

        // R4 / R9: unlock block 3.
        wr(3, 8'h55, 1'b1);
        chk(3, "R4 unlock R9");
        // R8: supply lockout vetoes an unlocked block.
        vpp_low = 1'b1;
        chk(3, "R8 vpp_low");
        vpp_low = 1'b0;
        // R3: strobe without chip enable is ignored.
        wr(4, 8'h55, 1'b0);
        chk(4, "R3 ce_n high");
        // R10: unknown code leaves unlocked block 3 alone.
        wr(3, 8'hFF, 1'b1);
        chk(3, "R10 unknown");
        // R4: lock block 3 again.
        wr(3, 8'h4C, 1'b1);
        chk(3, "R4 lock");

        // R5: lock-down under write-protect, unlock refused.
        wr(2, 8'h55, 1'b1);
        wr(2, 8'h44, 1'b1);
        chk(2, "R5 lockdown");
        wr(2, 8'h55, 1'b1);
        chk(2, "R5 unlock refused");

        // R6 / R11: write-protect high, marked block can be unlocked, relocked.
        wp_n = 1'b1;
        wr(2, 8'h55, 1'b1);
        chk(2, "R6 unlock R11 mark kept");
        wr(2, 8'h4C, 1'b1);
        chk(2, "R6 relock");
        wr(2, 8'h55, 1'b1);
        // R11: lock-down with write-protect high records the mark.
        wr(6, 8'h44, 1'b1);
        chk(6, "R11 mark wp high");
        wr(6, 8'h55, 1'b1);
        chk(6, "R6 unlock 6");

        // R7: write-protect low re-locks both marked blocks.
        @(negedge clk);
        wp_n = 1'b0;
        for (int k = 0; k < 8; k++) if (exp_mk[k]) exp_lk[k] = 1'b1;
        @(negedge clk);
        chk(2, "R7 reapply 2");
        chk(6, "R7 reapply 6");
        wr(6, 8'h55, 1'b1);
        chk(6, "R5 refused after R7");

        // R12: outputs driven for a selected read.
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        #1 cmp("R12 out_drv", int'(out_drv), 1);
        // R1: power-down floats outputs, ignores commands, forces state.
        @(negedge clk);
        pd_n = 1'b0;
        #1 cmp("R1 out_drv pd", int'(out_drv), 0);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        all_locked_model();
        wr(1, 8'h55, 1'b1);
        chk(1, "R1 cmd ignored");
        @(negedge clk);
        pd_n = 1'b1;
        @(negedge clk);
        // R2: after power-down release all locked, marks gone.
        chk(2, "R2 pd release 2");
        chk(6, "R2 pd release 6");
        // Mark cleared, so unlock now works with write-protect low.
        wr(6, 8'h55, 1'b1);
        chk(6, "R2 mark cleared");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule